// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A behavioural, synthesizable synchronous static memory with a registered address/control path and a registered output stage. Words are 18 bits wide and split into two 9-bit byte lanes; the depth is set by a parameter. An access is opened by one of two address strobes. The processor strobe is gated by the master chip enable and always opens a read. The controller strobe is not gated and opens either a read or a write. Once an access is open, a burst advance input steps a 2-bit burst counter through either a linear or an interleaved order. Lane write enables then turn each later cycle into a read or a write.

Read data for an address registered on one rising edge leaves the output register on the next rising edge. Data output is qualified by an asynchronous output enable. When a read access is closed by a deselect, the output keeps driving one cycle longer than the pipeline alone would (double-cycle deselect). A snooze input freezes all internal state, ignores every other input and turns the output drive off.

Bus state machine: `ST_IDLE` (no access open), `ST_READ` (last access was a read), `ST_WRITE` (last access was a write), `ST_DRAIN` (deselected right after a read, output still held). Transitions on each edge without snooze:
- select: a strobe with the chip selected goes to `ST_READ` or `ST_WRITE`.
- deselect: a strobe with the chip not selected goes from `ST_READ` to `ST_DRAIN`, and from any other state to `ST_IDLE`.
- continue: with no strobe, `ST_READ`/`ST_WRITE` go to `ST_WRITE` if a write enable is active, else to `ST_READ`.
- retire: with no strobe, `ST_DRAIN` and `ST_IDLE` go to `ST_IDLE`.

Top module: `ssram_pipe_burst`

## Requirements
- R1: When `proc_stb_n` is low and `ce0_n` is low on an edge, that edge opens a read if the chip is selected. This holds whatever the write enables and `ctrl_stb_n` are.
- R2: When `ce0_n` is high, a low `proc_stb_n` is treated as high. If `ctrl_stb_n` is also high, an open burst continues. If `ctrl_stb_n` is low, a controller cycle runs, and because `ce0_n` is high it deselects.
- R3: A controller cycle starts when `ctrl_stb_n` is low and the processor strobe is not effective. Its write enables are sampled on that same edge, and a write stores `dq_in` of that edge at `addr`.
- R4: Data read at an address registered on edge k appears on `dq_out`, with `dq_drive` high, after edge k+1.
- R5: `glob_wr_n` low writes all 18 bits, whatever `byte_wr_n` and `lane_wr_n` are.
- R6: With `glob_wr_n` high and `byte_wr_n` low, lane i is written when `lane_wr_n[i]` is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9. If no lane is enabled, the cycle is a read.
- R7: Lane write enables are ignored on an edge that opens a processor-strobe read. On later edges of the burst they are sampled, and they write `dq_in` at the current burst address.
- R8: After an edge on which a write is performed, `dq_drive` is low, whatever `oe_n` is.
- R9: `dq_drive` follows `oe_n` combinationally: it is high only while `oe_n` is low and read data is pending.
- R10: When a deselect edge d follows a read, `dq_drive` stays high after edges d and d+1 and drops after edge d+2 (if `oe_n` is low and no new read has been opened).
- R11: While `snooze` is high, `dq_drive` is low and no input changes the memory contents or the burst, state and output registers.
- R12: With `adv_n` low and no strobe, the burst counter c steps by one modulo 4. The low two address bits become base+c (modulo 4) when `linear_sel` is 1, or base XOR c when it is 0. With `adv_n` high, the address is held.
- R13: The chip is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0 on the strobe edge. Any other combination makes the strobe a deselect.
- R14: While reset is active and after it is released, `dq_drive` is low until a read is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address sampled on a strobe edge |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by ce0_n |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce0_n | input | 1 | Master chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Enables the per-lane write enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| linear_sel | input | 1 | Burst order: 1 linear, 0 interleaved |
| snooze | input | 1 | Power-down: freezes state, output drive off |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data from the output register |
| dq_drive | output | 1 | High when dq_out should be driven onto the bus |

## Verification
A write takes effect on the edge that samples it. Read data and the drive flag are due one edge after the access edge, and the double-cycle deselect tail ends two edges after the deselect. The bench keeps a behavioural model that is updated on every rising edge from the inputs sampled there. Each check is made 3 ns after that edge, once the output register has settled and before any input is changed for the next edge. Output enable is also probed between edges with a 1 ns settle, because it acts without a clock.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

    // Bus state: what the last clocked access left in the pipeline.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DRAIN = 2'd3
    } bus_state_t;

endpackage

// File: rtl/ssram_burst_gen.sv
module ssram_burst_gen #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              load,
    input  logic              step,
    input  logic              linear_sel,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_inc;
    logic [BURST_W-1:0] lo_cur;
    logic [BURST_W-1:0] lo_nxt;
    logic [HI_W-1:0]    hi_part;

    assign cnt_inc = cnt_q + 1'b1;
    assign hi_part = base_q[ADDR_W-1:BURST_W];

    always_comb begin
        if (linear_sel) begin
            lo_cur = base_q[BURST_W-1:0] + cnt_q;
            lo_nxt = base_q[BURST_W-1:0] + cnt_inc;
        end else begin
            lo_cur = base_q[BURST_W-1:0] ^ cnt_q;
            lo_nxt = base_q[BURST_W-1:0] ^ cnt_inc;
        end
    end

    assign cur_addr  = {hi_part, lo_cur};
    assign next_addr = {hi_part, lo_nxt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (upd_en) begin
            if (load) begin
                base_q <= load_addr;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && step && !load) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R12

    AST_BURST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && load) |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode #(
    parameter int LANES = 2
) (
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             glob_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             burst_live,
    output logic             start,
    output logic             sel,
    output logic             start_wr,
    output logic             cont_wr,
    output logic [LANES-1:0] wr_lanes
);

    logic proc_go;
    logic ctrl_go;
    logic any_lane;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_lanes[g] = !glob_wr_n || (!byte_wr_n && !lane_wr_n[g]);
    end

    assign any_lane = |wr_lanes;
    assign proc_go  = !proc_stb_n && !ce0_n;
    assign ctrl_go  = !proc_go && !ctrl_stb_n;
    assign start    = proc_go || ctrl_go;
    assign sel      = !ce0_n && ce1 && !ce2_n;
    assign start_wr = ctrl_go && any_lane;
    assign cont_wr  = burst_live && !start && any_lane;

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/ssram_pipe_burst.sv
module ssram_pipe_burst
    import ssram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic              glob_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic              linear_sel,
    input  logic              snooze,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    bus_state_t st_q, st_n, open_st;

    logic              burst_live;
    logic              start, sel, start_wr, cont_wr;
    logic [LANES-1:0]  wr_lanes;
    logic              upd_en, load, step, do_wr, is_access;
    logic [ADDR_W-1:0] cur_addr, next_addr, acc_addr, acc_q;
    logic [DATA_W-1:0] rdata, dout_q;
    logic              vis_q, vis_n;

    assign burst_live = (st_q == ST_READ) || (st_q == ST_WRITE);
    assign upd_en     = !snooze;

    ssram_cmd_decode #(.LANES(LANES)) i_decode (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .ce0_n      (ce0_n),
        .ce1        (ce1),
        .ce2_n      (ce2_n),
        .glob_wr_n  (glob_wr_n),
        .byte_wr_n  (byte_wr_n),
        .lane_wr_n  (lane_wr_n),
        .burst_live (burst_live),
        .start      (start),
        .sel        (sel),
        .start_wr   (start_wr),
        .cont_wr    (cont_wr),
        .wr_lanes   (wr_lanes)
    );

    assign load      = start && sel;
    assign step      = burst_live && !start && !adv_n;
    assign is_access = load || (burst_live && !start);
    assign do_wr     = upd_en && ((load && start_wr) || cont_wr);

    ssram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .load       (load),
        .step       (step),
        .linear_sel (linear_sel),
        .load_addr  (addr),
        .cur_addr   (cur_addr),
        .next_addr  (next_addr)
    );

    always_comb begin
        if (start)       acc_addr = addr;
        else if (!adv_n) acc_addr = next_addr;
        else             acc_addr = cur_addr;
    end

    ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk     (clk),
        .wr_en   (do_wr),
        .lane_en (wr_lanes),
        .waddr   (acc_addr),
        .wdata   (dq_in),
        .raddr   (acc_q),
        .rdata   (rdata)
    );

    // Next-state logic
    assign open_st = start_wr ? ST_WRITE : ST_READ;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_n = sel ? open_st : ST_IDLE;
                else       st_n = ST_IDLE;
            end
            ST_READ: begin
                if (start) st_n = sel ? open_st : ST_DRAIN;
                else       st_n = cont_wr ? ST_WRITE : ST_READ;
            end
            ST_WRITE: begin
                if (start) st_n = sel ? open_st : ST_IDLE;
                else       st_n = cont_wr ? ST_WRITE : ST_READ;
            end
            ST_DRAIN: begin
                if (start) st_n = sel ? open_st : ST_IDLE;
                else       st_n = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            acc_q <= '0;
        end else if (upd_en) begin
            st_q <= st_n;
            if (is_access) acc_q <= acc_addr;
        end
    end

    // Output stage
    assign vis_n = !do_wr && ((st_q == ST_READ) || (st_q == ST_DRAIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q  <= 1'b0;
            dout_q <= '0;
        end else if (upd_en) begin
            vis_q <= vis_n;
            if (st_q == ST_READ) dout_q <= rdata;
        end
    end

    assign dq_out   = dout_q;
    assign dq_drive = vis_q && !oe_n && !snooze;

    AST_PROC_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && !proc_stb_n && !ce0_n && ce1 && !ce2_n) |=> (st_q == ST_READ)); // R1

    AST_CE0_BLOCKS_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && !proc_stb_n && ce0_n && ctrl_stb_n && st_q == ST_IDLE) |=> (st_q == ST_IDLE)); // R2

    AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && st_q == ST_READ && !do_wr) |=> vis_q); // R4

    AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> !vis_q); // R8

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && st_q == ST_DRAIN && !do_wr) |=> vis_q); // R10

    AST_SNOOZE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> ($stable(st_q) && $stable(acc_q) && $stable(vis_q) && $stable(dout_q))); // R11

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && start && !sel && st_q != ST_READ) |=> (st_q == ST_IDLE)); // R13

endmodule

// File: tb/test_ssram_pipe_burst.sv
module test_ssram_pipe_burst;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr;
    logic        ps_n, cs_n, adv_n, ce0_n, ce1, ce2_n, gw_n, bwe_n, oe_n, linear, snooze;
    logic [1:0]  lw_n;
    logic [17:0] dq_in;
    logic [17:0] dq_out;
    logic        dq_drive;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string cur_tag = "R14";

    // behavioural reference: 0 idle, 1 read, 2 write, 3 drain
    int          m_mode = 0;
    int          m_base = 0;
    int          m_cnt  = 0;
    int          m_acc  = 0;
    bit          m_vis  = 0;
    logic [17:0] m_dout = '0;
    logic [17:0] mem [256];

    always #10 clk = ~clk;

    ssram_pipe_burst i_ssram_pipe_burst (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_stb_n(ps_n), .ctrl_stb_n(cs_n), .adv_n(adv_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .glob_wr_n(gw_n), .byte_wr_n(bwe_n), .lane_wr_n(lw_n),
        .oe_n(oe_n), .linear_sel(linear), .snooze(snooze),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    function automatic int baddr(int b, int c);
        int lo;
        lo = linear ? (((b & 3) + c) & 3) : ((b & 3) ^ (c & 3));
        return (b & ~3) | lo;
    endfunction

    task automatic model_edge();
        int  lanes;
        bit  pgo, cgo, go, sel, live, wr, nvis;
        if (snooze) return;
        lanes = !gw_n ? 3 : (!bwe_n ? (~int'(lw_n)) & 3 : 0);
        pgo   = !ps_n && !ce0_n;
        cgo   = !pgo && !cs_n;
        go    = pgo || cgo;
        sel   = !ce0_n && ce1 && !ce2_n;
        live  = (m_mode == 1) || (m_mode == 2);
        nvis  = (m_mode == 1) || (m_mode == 3);
        if (m_mode == 1) m_dout = mem[m_acc];
        wr = 0;
        if (go) begin
            if (sel) begin
                m_base = int'(addr); m_cnt = 0; m_acc = int'(addr);
                wr = cgo && (lanes != 0);
                m_mode = wr ? 2 : 1;
            end else begin
                m_mode = (m_mode == 1) ? 3 : 0;
            end
        end else if (live) begin
            if (!adv_n) m_cnt = (m_cnt + 1) & 3;
            m_acc = baddr(m_base, m_cnt);
            wr = (lanes != 0);
            m_mode = wr ? 2 : 1;
        end else begin
            m_mode = 0;
        end
        if (wr) begin
            if (lanes & 1) mem[m_acc][8:0]  = dq_in[8:0];
            if (lanes & 2) mem[m_acc][17:9] = dq_in[17:9];
            nvis = 0;
        end
        m_vis = nvis;
    endtask

    always @(posedge clk) if (rst_n) model_edge();

    task automatic chk(string what, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        bit e;
        e = m_vis && !oe_n && !snooze;
        chk("dq_drive", {17'd0, dq_drive}, {17'd0, e});
        if (e) chk("dq_out", dq_out, m_dout);
    endtask

    task automatic step(string t);
        cur_tag = t;
        @(posedge clk);
        #3;
        compare_now();
    endtask

    task automatic idle();
        ps_n = 1; cs_n = 1; adv_n = 1; ce0_n = 0; ce1 = 1; ce2_n = 0;
        gw_n = 1; bwe_n = 1; lw_n = 2'b11; oe_n = 0; snooze = 0;
        addr = '0; dq_in = '0;
    endtask

    task automatic deselect(string t);
        idle(); cs_n = 0; ce1 = 0; step(t);
        idle(); step(t); step(t); step(t);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        linear = 1;
        #35;
        cur_tag = "R14";
        chk("dq_drive in reset", {17'd0, dq_drive}, 18'd0);
        rst_n = 1;
        step("R14");
        step("R14");

        // R3 / R5: controller write burst, global write
        idle(); cs_n = 0; addr = 8'h10; gw_n = 0; dq_in = 18'h0A5A1; step("R3");
        idle(); gw_n = 0; adv_n = 0; dq_in = 18'h1B6B2; step("R5");
        idle(); gw_n = 0; adv_n = 0; dq_in = 18'h2C7C3; step("R5");
        idle(); gw_n = 0; adv_n = 0; dq_in = 18'h3D8D4; step("R5");
        deselect("R13");

        // R1 / R4: processor read with write enables and controller strobe low
        idle(); ps_n = 0; cs_n = 0; gw_n = 0; addr = 8'h10; step("R1");
        idle(); adv_n = 0; step("R4");
        idle(); adv_n = 0; step("R4");
        idle(); adv_n = 0; step("R4");
        // R10: double-cycle deselect tail
        idle(); cs_n = 0; ce2_n = 1; step("R10");
        idle(); step("R10"); step("R10"); step("R10");

        // R12: interleaved order from base 1
        linear = 0;
        idle(); linear = 0; ps_n = 0; addr = 8'h11; step("R12");
        for (int i = 0; i < 3; i++) begin idle(); linear = 0; adv_n = 0; step("R12"); end
        idle(); linear = 0; step("R12");
        step("R12");
        linear = 1;
        deselect("R12");
        // R12: linear order from base 1
        idle(); ps_n = 0; addr = 8'h11; step("R12");
        for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; step("R12"); end
        deselect("R12");

        // R6: lane writes
        idle(); cs_n = 0; addr = 8'h20; gw_n = 0; dq_in = 18'h3FFFF; step("R6");
        deselect("R6");
        idle(); cs_n = 0; addr = 8'h20; bwe_n = 0; lw_n = 2'b10; dq_in = 18'h00000; step("R6");
        deselect("R6");
        idle(); cs_n = 0; addr = 8'h20; bwe_n = 0; lw_n = 2'b11; dq_in = 18'h11111; step("R6");
        idle(); step("R6"); step("R6");
        deselect("R6");

        // R7: lane enables ignored on processor edge, sampled afterwards
        idle(); ps_n = 0; addr = 8'h30; bwe_n = 0; lw_n = 2'b00; dq_in = 18'h12345; step("R7");
        idle(); bwe_n = 0; lw_n = 2'b01; dq_in = 18'h2A955; step("R7");
        idle(); bwe_n = 0; lw_n = 2'b10; dq_in = 18'h000AA; step("R7");
        idle(); step("R7"); step("R7");
        deselect("R7");

        // R8: a write edge mutes the output
        idle(); ps_n = 0; addr = 8'h10; step("R8");
        idle(); step("R8");
        idle(); gw_n = 0; dq_in = 18'h15555; step("R8");
        idle(); step("R8"); step("R8");
        deselect("R8");

        // R9: output enable acts without a clock
        idle(); ps_n = 0; addr = 8'h11; step("R9");
        idle(); step("R9");
        cur_tag = "R9";
        oe_n = 1; #1; chk("dq_drive oe high", {17'd0, dq_drive}, 18'd0);
        oe_n = 0; #1; chk("dq_drive oe low", {17'd0, dq_drive}, 18'd1);

        // R2: blocked processor strobe continues burst; controller strobe still deselects
        idle(); ps_n = 0; ce0_n = 1; adv_n = 0; addr = 8'h33; step("R2");
        idle(); step("R2");
        idle(); ps_n = 0; ce0_n = 1; cs_n = 0; addr = 8'h33; step("R2");
        idle(); step("R2"); step("R2"); step("R2");

        // R13: deselect when a chip enable is inactive
        idle(); ps_n = 0; ce2_n = 1; addr = 8'h12; step("R13");
        idle(); step("R13");
        idle(); ps_n = 0; ce1 = 0; addr = 8'h12; step("R13");
        idle(); step("R13");

        // R11: snooze freezes everything
        idle(); ps_n = 0; addr = 8'h12; step("R11");
        idle(); step("R11");
        for (int i = 0; i < 2; i++) begin
            idle(); snooze = 1; cs_n = 0; gw_n = 0; addr = 8'h13; dq_in = 18'h0; step("R11");
        end
        idle(); step("R11"); step("R11");
        deselect("R11");
        idle(); ps_n = 0; addr = 8'h13; step("R11");
        idle(); step("R11"); step("R11");
        deselect("R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule